// File: doc/BRIEF.md
# Shift-Up Event Queue

This block gathers 8-bit event records from several on-chip producers, such as key scanning, input-change detection and combinational logic monitors. It keeps up to sixteen of them in arrival order for a host that reads them through a register window. Each record holds a 7-bit identifier in bits [6:0] and a state bit in bit 7, where 1 means active or pressed and 0 means inactive or released. A 5-bit occupancy count tells the host how many records are waiting. Every address in the read window shows only the oldest record. Each read strobe retires that record and moves every later record one slot toward the head.

Producers connect through valid/ready ports. `src_ready[i]` is high, in the same cycle, only for the highest-priority valid producer. A producer must hold `src_valid[i]` and its data until it sees ready. The queue never stalls a granted producer. When there is no room for its record, the record is dropped and the sticky overflow flag is set. Records pass through a small pending buffer before they reach storage. While the host has a transaction open on the read window (`win_busy`), nothing moves from the pending buffer into storage. After the transaction ends, the pending records move one per cycle.

Top module: `evq_top`

## Requirements
- R1: A record is returned unchanged. Bit 7 is the state and bits [6:0] are the identifier.
- R2: `count` rises by one for each record placed in storage and falls by one for each read strobe taken while `count` is nonzero. It never exceeds the storage depth of 16.
- R3: `rd_data` always shows the oldest stored record, so records leave in arrival order.
- R4: After a read strobe, the record that was second oldest becomes the head on the following cycle.
- R5: While `win_busy` is high, or in a cycle with `rd_req` high, no record enters storage. Held records then enter one per cycle, so the count rises by one on each edge after `win_busy` falls.
- R6: A record arriving at full storage is discarded and the 16 stored records stay unchanged. `ovf_flag` is set and stays set until cleared.
- R7: A record accepted while the pending buffer (4 deep) is full and not draining is discarded and sets `ovf_flag`.
- R8: `ovf_irq` is high exactly when `ovf_flag` is set and `ovf_irq_en` is high.
- R9: `evt_irq` is set when a record enters storage. It stays set until a `clr_evt` strobe and can be cleared while storage is empty. A `clr_ovf` strobe clears `ovf_flag`.
- R10: With several producers valid, one record is accepted per cycle in the fixed order key (index 0), input-change (index 1), logic (index 2).
- R11: A read at empty storage returns 0x00 and leaves `count` at 0.
- R12: After reset, `count` is 0, `rd_data` is 0x00, and both interrupts and `ovf_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 3 | Producer record valid, index 0 highest priority |
| src_data | input | 24 | Producer records, 8 bits per producer at [8i+7:8i] |
| src_ready | output | 3 | Producer record accepted this cycle |
| win_busy | input | 1 | Host transaction open on the read window |
| rd_req | input | 1 | Host read strobe, one record per cycle high |
| rd_data | output | 8 | Oldest stored record, or 0x00 when empty |
| count | output | 5 | Number of stored records |
| clr_ovf | input | 1 | Write-1 strobe clearing the overflow flag |
| clr_evt | input | 1 | Write-1 strobe clearing the event interrupt |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | Overflow interrupt |
| evt_irq | output | 1 | Event interrupt |

## Verification
The assertions check, on every cycle, the bound on the count, the one-hot priority grant, the one-step count fall after a read, the absence of count growth while the window is busy, the sticky overflow flag, the overflow interrupt gating, and the zero read value when storage is empty. Only the bench's scenarios can show the record contents and their order after shifting. The same holds for the priority order as it appears in stored data, the one-per-cycle drain after a pause, and the fact that the 16 surviving records are the first ones to arrive, with the dropped record nowhere in storage.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int REC_W = 8;
  localparam int ID_W  = 7;
  typedef logic [REC_W-1:0] rec_t;
endpackage

// File: rtl/evq_arb.sv
// Fixed-priority pick of one producer per cycle; lowest index wins.
module evq_arb
  import evq_pkg::*;
#(
  parameter int NSRC = 3
) (
  input  logic [NSRC-1:0]       src_valid,
  input  logic [NSRC*REC_W-1:0] src_data,
  output logic [NSRC-1:0]       src_ready,
  output logic                  out_valid,
  output rec_t                  out_data
);
  always_comb begin
    src_ready = '0;
    out_valid = 1'b0;
    out_data  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (src_valid[i]) begin
        src_ready = '0;
        src_ready[i] = 1'b1;
        out_valid = 1'b1;
        out_data  = src_data[i*REC_W +: REC_W];
      end
    end
  end
endmodule

// File: rtl/evq_pend.sv
// Small holding buffer between producers and storage.
module evq_pend
  import evq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  rec_t push_data,
  input  logic pop,
  output logic nonempty,
  output rec_t head,
  output logic drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rec_t             mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] fill;
  logic             full, do_push, do_pop;

  assign full     = (fill == CNT_W'(DEPTH));
  assign nonempty = (fill != '0);
  assign do_pop   = pop && nonempty;
  assign do_push  = push && (!full || do_pop);
  assign drop     = push && !do_push;
  assign head     = mem[rptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end
endmodule

// File: rtl/evq_store.sv
// Shift-up storage: slot 0 is the head, reads move every slot down by one.
module evq_store
  import evq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  rec_t             wr_data,
  input  logic             rd_en,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output rec_t             head
);
  rec_t slot [DEPTH];
  logic take, put;

  assign full = (count == CNT_W'(DEPTH));
  assign take = rd_en && (count != '0);
  assign put  = wr_en && !full && !take;
  assign head = (count == '0) ? '0 : slot[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == DEPTH - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (!rst_n)                                slot[i] <= '0;
        else if (take)                             slot[i] <= '0;
        else if (put && count == CNT_W'(i))        slot[i] <= wr_data;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rst_n)                                slot[i] <= '0;
        else if (take)                             slot[i] <= slot[i+1];
        else if (put && count == CNT_W'(i))        slot[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (take) count <= count - 1'b1;
    else if (put)  count <= count + 1'b1;
  end
endmodule

// File: rtl/evq_top.sv
module evq_top
  import evq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int PEND_DEPTH = 4,
  parameter int NSRC       = 3,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_valid,
  input  logic [NSRC*REC_W-1:0] src_data,
  output logic [NSRC-1:0]       src_ready,
  input  logic                  win_busy,
  input  logic                  rd_req,
  output logic [REC_W-1:0]      rd_data,
  output logic [CNT_W-1:0]      count,
  input  logic                  clr_ovf,
  input  logic                  clr_evt,
  input  logic                  ovf_irq_en,
  output logic                  ovf_flag,
  output logic                  ovf_irq,
  output logic                  evt_irq
);
  logic arb_valid, pend_ne, pend_drop, pop, store_full;
  rec_t arb_data, pend_head;

  evq_arb #(.NSRC(NSRC)) u_arb (
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .out_valid(arb_valid), .out_data(arb_data)
  );

  // Storage updates stay frozen during a window access or a read strobe.
  assign pop = pend_ne && !win_busy && !rd_req;

  evq_pend #(.DEPTH(PEND_DEPTH)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(arb_valid), .push_data(arb_data),
    .pop(pop), .nonempty(pend_ne), .head(pend_head), .drop(pend_drop)
  );

  evq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(pop), .wr_data(pend_head),
    .rd_en(rd_req), .count(count), .full(store_full), .head(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      evt_irq  <= 1'b0;
    end else begin
      if (pend_drop || (pop && store_full)) ovf_flag <= 1'b1;
      else if (clr_ovf)                     ovf_flag <= 1'b0;
      if (pop && !store_full)               evt_irq  <= 1'b1;
      else if (clr_evt)                     evt_irq  <= 1'b0;
    end
  end

  assign ovf_irq = ovf_flag && ovf_irq_en;
endmodule

// File: rtl/evq_chk.sv
module evq_chk #(
  parameter int DEPTH = 16,
  parameter int NSRC  = 3,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_valid,
  input logic [NSRC-1:0]  src_ready,
  input logic             win_busy,
  input logic             rd_req,
  input logic [7:0]       rd_data,
  input logic [CNT_W-1:0] count,
  input logic             clr_ovf,
  input logic             ovf_irq_en,
  input logic             ovf_flag,
  input logic             ovf_irq
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2
  AST_READ_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && count != '0) |=> (count == $past(count) - 1'b1)); // R2
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    win_busy |=> (count <= $past(count))); // R5
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready) && ((src_ready & ~src_valid) == '0)); // R10
  AST_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid[0] |-> src_ready[0]); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag); // R6
  AST_OVF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq == (ovf_flag && ovf_irq_en)); // R8
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (rd_data == 8'h00)); // R11
endmodule

bind evq_top evq_chk #(.DEPTH(DEPTH), .NSRC(NSRC), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .win_busy(win_busy), .rd_req(rd_req), .rd_data(rd_data), .count(count),
  .clr_ovf(clr_ovf), .ovf_irq_en(ovf_irq_en), .ovf_flag(ovf_flag),
  .ovf_irq(ovf_irq)
);

// File: tb/evq_top_tb.sv
module evq_top_tb;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  src_valid = '0;
  logic [23:0] src_data = '0;
  logic [2:0]  src_ready;
  logic        win_busy = 0, rd_req = 0, clr_ovf = 0, clr_evt = 0, ovf_irq_en = 0;
  logic [7:0]  rd_data;
  logic [4:0]  count;
  logic        ovf_flag, ovf_irq, evt_irq;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  evq_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .win_busy(win_busy), .rd_req(rd_req),
    .rd_data(rd_data), .count(count), .clr_ovf(clr_ovf), .clr_evt(clr_evt),
    .ovf_irq_en(ovf_irq_en), .ovf_flag(ovf_flag), .ovf_irq(ovf_irq),
    .evt_irq(evt_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(input int s, input logic [7:0] d);
    src_valid[s] = 1'b1;
    src_data[s*8 +: 8] = d;
    step();
    src_valid[s] = 1'b0;
  endtask

  task automatic read_ev(output logic [7:0] d);
    rd_req = 1'b1;
    d = rd_data;
    step();
    rd_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 count", count, 0);
    chk("R12 rd_data", rd_data, 0);
    chk("R12 irqs", {ovf_flag, ovf_irq, evt_irq}, 0);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    send(0, 8'h83); send(0, 8'h03); send(0, 8'h07);
    step();
    chk("R2 count after 3", count, 3);
    chk("R9 evt_irq set", evt_irq, 1);
    read_ev(d); chk("R1 R3 first", d, 8'h83);
    chk("R2 count dec", count, 2);
    chk("R4 new head", rd_data, 8'h03);
    read_ev(d); chk("R3 second", d, 8'h03);
    read_ev(d); chk("R3 third", d, 8'h07);
    read_ev(d); chk("R11 empty read", d, 8'h00);
    chk("R11 count stays 0", count, 0);
    chk("R9 evt_irq held", evt_irq, 1);
    clr_evt = 1; step(); clr_evt = 0;
    chk("R9 clear when empty", evt_irq, 0);
  endtask

  task automatic t_prio();
    logic [7:0] d;
    src_data = {8'h33, 8'h22, 8'h91};
    src_valid = 3'b111; #1;
    chk("R10 grant key", src_ready, 3'b001);
    step(); src_valid[0] = 0; #1;
    chk("R10 grant input-change", src_ready, 3'b010);
    step(); src_valid[1] = 0; #1;
    chk("R10 grant logic", src_ready, 3'b100);
    step(); src_valid[2] = 0;
    step();
    chk("R10 count", count, 3);
    read_ev(d); chk("R10 order 1", d, 8'h91);
    read_ev(d); chk("R10 order 2", d, 8'h22);
    read_ev(d); chk("R10 order 3", d, 8'h33);
    clr_evt = 1; step(); clr_evt = 0;
  endtask

  task automatic t_pause();
    logic [7:0] d;
    win_busy = 1;
    send(1, 8'h0A); send(1, 8'h0B); send(1, 8'h8C);
    step(); step();
    chk("R5 no store while busy", count, 0);
    win_busy = 0;
    step(); chk("R5 drain one", count, 1);
    step(); chk("R5 drain two", count, 2);
    step(); chk("R5 drain three", count, 3);
    read_ev(d); chk("R5 order", d, 8'h0A);
    read_ev(d); read_ev(d); chk("R5 last", d, 8'h8C);
    chk("R7 no overflow yet", ovf_flag, 0);
  endtask

  task automatic t_pend_ovf();
    logic [7:0] d;
    win_busy = 1;
    for (int k = 1; k <= 5; k++) send(2, 8'(k));
    chk("R7 pending overflow", ovf_flag, 1);
    win_busy = 0;
    step(); step(); step(); step(); step();
    chk("R7 four kept", count, 4);
    for (int k = 1; k <= 4; k++) begin
      read_ev(d); chk("R7 kept data", d, k);
    end
    clr_ovf = 1; step(); clr_ovf = 0;
    chk("R9 ovf cleared", ovf_flag, 0);
  endtask

  task automatic t_store_ovf();
    logic [7:0] d;
    for (int k = 0; k < 16; k++) send(0, 8'h40 + 8'(k));
    step();
    chk("R2 full count", count, 16);
    chk("R6 no ovf at 16", ovf_flag, 0);
    send(0, 8'h7F); step();
    chk("R6 count holds", count, 16);
    chk("R6 ovf set", ovf_flag, 1);
    ovf_irq_en = 1; #1;
    chk("R8 irq enabled", ovf_irq, 1);
    ovf_irq_en = 0; #1;
    chk("R8 irq masked", ovf_irq, 0);
    for (int k = 0; k < 16; k++) begin
      read_ev(d); chk("R6 entries unchanged", d, 8'h40 + k);
    end
    chk("R6 drop gone", count, 0);
    chk("R6 flag sticky", ovf_flag, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_basic();
    t_prio();
    t_pause();
    t_pend_ovf();
    t_store_ovf();
    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule